// File: doc/BRIEF.md
# Pixel Sparse Readout with Digital CDS

This block sits after the converter of a pixel sensor that is digitized one row at a time. Each 12-bit pixel sample arrives on a valid/ready stream with its row and column index. The block holds one reference word per pixel in an on-chip RAM. In every frame that is not triggered, each sample overwrites its own reference word, so the stored frame always holds the most recent baseline.

A trigger pulse arms the block. The next frame that starts at row 0, column 0 becomes a signal frame. For each pixel of that frame, the stored reference is subtracted from the new sample. A negative result is clamped to zero, and the difference is compared against a programmable threshold. Only pixels that reach the threshold leave the block, as words tagged with their row and column. Rows with no such pixel therefore produce nothing. One end-of-frame word closes each signal frame.

The reference RAM is frozen for the whole of a signal frame. Further triggers during that frame are discarded. The output stream can stall, and a stall back-pressures the sample input without losing any pixel.

Top module: `spx_readout`

## Requirements
- R1: After reset, `m_valid` is low, `s_ready` is high and no trigger is armed.
- R2: A frame read while no trigger is armed emits no output word. Each of its samples replaces the stored reference of its pixel.
- R3: In a signal frame, the difference reported for a pixel is its new sample minus the reference last written for that pixel.
- R4: When the sample is below the reference, the difference is taken as zero before thresholding. A threshold of 0 therefore emits such pixels with `m_diff` = 0.
- R5: A pixel of a signal frame is emitted if and only if its difference is greater than or equal to `thresh`. The threshold must be held steady while a signal frame is in flight.
- R6: Each hit word carries `m_eof` = 0, the pixel's `m_row`, its `m_col` and its difference on `m_diff`. Hits leave in sample order, row by row and column by column. A row without hits contributes no word.
- R7: After the last pixel (row ROWS-1, column COLS-1) of every signal frame, exactly one word with `m_eof` = 1 and row, column and difference all zero is emitted. This word appears even when the frame has no hits.
- R8: A trigger seen in the middle of an unarmed frame leaves that frame a refresh frame. It takes effect at the next frame start.
- R9: A trigger seen while a signal frame is in progress is ignored. The frame after it is a refresh frame.
- R10: The reference RAM is not written during a signal frame. A later signal frame subtracts the references of the last refresh frame.
- R11: While `m_valid` is high and `m_ready` is low, the output word stays unchanged. The input stalls (`s_ready` low) once the internal stage is full, and no sample is lost or repeated.
- R12: With `m_ready` held high, a hit word is valid right after the second clock edge counted from the edge that accepts its sample, that edge included. The end-of-frame word follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample accepted this cycle when high with s_valid |
| s_row | input | clog2(ROWS) | Row index of the sample |
| s_col | input | clog2(COLS) | Column index of the sample |
| s_pixel | input | 12 | Converted pixel value, unsigned |
| trig | input | 1 | Trigger pulse, arms the next frame |
| thresh | input | 12 | Hit threshold, inclusive |
| m_valid | output | 1 | Output word present |
| m_ready | input | 1 | Consumer takes the word when high with m_valid |
| m_row | output | clog2(ROWS) | Row of the hit, 0 on end-of-frame |
| m_col | output | clog2(COLS) | Column of the hit, 0 on end-of-frame |
| m_diff | output | 12 | Clamped CDS difference, 0 on end-of-frame |
| m_eof | output | 1 | Marks the end-of-frame word |

## Verification
A sample is accepted on one edge and moves into the difference stage there. Its hit word becomes visible after the next edge, and the end-of-frame word after the edge that follows. The driver records the edge count at which each sample is taken and files the expected word with the cycle it is due. While `m_ready` is held high, the monitor compares the arrival cycle with that due cycle. In a back-pressured frame, arrival time is left open and only order, content and the holding of stalled words are checked. Every refresh frame and every ignored trigger is followed by an idle drain, and the drain confirms that no word appeared.

// File: rtl/spx_pkg.sv
`timescale 1ns/1ps
package spx_pkg;
  localparam int PIX_W = 12;
  typedef logic [PIX_W-1:0] pix_t;

  // Clamped difference of sample over stored baseline
  function automatic pix_t cds_diff(input pix_t smp, input pix_t base);
    return (smp > base) ? pix_t'(smp - base) : '0;
  endfunction

  // Inclusive threshold test
  function automatic logic over_thr(input pix_t diff, input pix_t thr);
    return diff >= thr;
  endfunction
endpackage

// File: rtl/spx_ref_ram.sv
`timescale 1ns/1ps
module spx_ref_ram #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int DW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Single port, registered read returning the value held before a write
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/spx_frame_ctl.sv
`timescale 1ns/1ps
module spx_frame_ctl #(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  parameter int RW   = 5,
  parameter int CW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          acc_i,
  input  logic [RW-1:0] row_i,
  input  logic [CW-1:0] col_i,
  output logic          sig_o,
  output logic          last_o
);
  logic armed_q, in_sig_q;
  logic first_pix;

  assign first_pix = (row_i == '0) && (col_i == '0);
  assign last_o    = (row_i == RW'(ROWS - 1)) && (col_i == CW'(COLS - 1));
  assign sig_o     = first_pix ? armed_q : in_sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      in_sig_q <= 1'b0;
    end else begin
      if (acc_i && first_pix && armed_q) begin
        in_sig_q <= 1'b1;
        armed_q  <= 1'b0;
      end else if (trig_i && !in_sig_q) begin
        armed_q <= 1'b1;
      end
      if (acc_i && last_o && sig_o) in_sig_q <= 1'b0;
    end
  end

  // R9
  trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sig_q |=> !$rose(armed_q));

  // R8
  armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !acc_i |=> armed_q);
endmodule

// File: rtl/spx_hit_out.sv
`timescale 1ns/1ps
module spx_hit_out #(
  parameter int RW = 5,
  parameter int CW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               p_valid,
  input  logic               p_sig,
  input  logic               p_last,
  input  logic [RW-1:0]      p_row,
  input  logic [CW-1:0]      p_col,
  input  spx_pkg::pix_t      p_smp,
  input  spx_pkg::pix_t      p_base,
  input  spx_pkg::pix_t      thr_i,
  output logic               p_take,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [RW-1:0]      m_row,
  output logic [CW-1:0]      m_col,
  output spx_pkg::pix_t      m_diff,
  output logic               m_eof
);
  spx_pkg::pix_t diff;
  logic hit, out_free, eof_pend;

  assign diff     = spx_pkg::cds_diff(p_smp, p_base);
  assign hit      = p_sig && spx_pkg::over_thr(diff, thr_i);
  assign out_free = !m_valid || m_ready;
  assign p_take   = p_valid && out_free && !eof_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_eof    <= 1'b0;
      m_row    <= '0;
      m_col    <= '0;
      m_diff   <= '0;
      eof_pend <= 1'b0;
    end else if (out_free) begin
      if (eof_pend) begin
        m_valid  <= 1'b1;
        m_eof    <= 1'b1;
        m_row    <= '0;
        m_col    <= '0;
        m_diff   <= '0;
        eof_pend <= 1'b0;
      end else if (p_valid) begin
        m_valid <= hit;
        m_eof   <= 1'b0;
        m_row   <= p_row;
        m_col   <= p_col;
        m_diff  <= diff;
        if (p_sig && p_last) eof_pend <= 1'b1;
      end else begin
        m_valid <= 1'b0;
      end
    end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable({m_eof, m_row, m_col, m_diff}));

  // R5
  hit_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_eof |-> m_diff >= thr_i);
endmodule

// File: rtl/spx_readout.sv
`timescale 1ns/1ps
module spx_readout #(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW  = (ROWS * COLS > 1) ? $clog2(ROWS * COLS) : 1,
  localparam int PW  = spx_pkg::PIX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [RW-1:0] s_row,
  input  logic [CW-1:0] s_col,
  input  logic [PW-1:0] s_pixel,
  input  logic          trig,
  input  logic [PW-1:0] thresh,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [RW-1:0] m_row,
  output logic [CW-1:0] m_col,
  output logic [PW-1:0] m_diff,
  output logic          m_eof
);
  logic          acc, sig_now, last_pix, p_take, p1_adv;
  logic          p1_valid, p1_sig, p1_last;
  logic [RW-1:0] p1_row;
  logic [CW-1:0] p1_col;
  spx_pkg::pix_t p1_smp, base_q;
  logic [AW-1:0] addr;

  assign p1_adv  = !p1_valid || p_take;
  assign s_ready = p1_adv;
  assign acc     = s_valid && s_ready;
  assign addr    = AW'(s_row) * AW'(COLS) + AW'(s_col);

  spx_frame_ctl #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .acc_i(acc),
    .row_i(s_row), .col_i(s_col), .sig_o(sig_now), .last_o(last_pix)
  );

  spx_ref_ram #(.DEPTH(ROWS * COLS), .AW(AW), .DW(PW)) u_ram (
    .clk(clk), .we(acc && !sig_now), .re(acc), .addr(addr),
    .wdata(s_pixel), .rdata(base_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_valid <= 1'b0;
      p1_sig   <= 1'b0;
      p1_last  <= 1'b0;
      p1_row   <= '0;
      p1_col   <= '0;
      p1_smp   <= '0;
    end else if (p1_adv) begin
      p1_valid <= acc;
      if (acc) begin
        p1_sig  <= sig_now;
        p1_last <= last_pix;
        p1_row  <= s_row;
        p1_col  <= s_col;
        p1_smp  <= s_pixel;
      end
    end
  end

  spx_hit_out #(.RW(RW), .CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .p_valid(p1_valid), .p_sig(p1_sig),
    .p_last(p1_last), .p_row(p1_row), .p_col(p1_col), .p_smp(p1_smp),
    .p_base(base_q), .thr_i(thresh), .p_take(p_take),
    .m_valid(m_valid), .m_ready(m_ready), .m_row(m_row), .m_col(m_col),
    .m_diff(m_diff), .m_eof(m_eof)
  );

  // R11
  in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p1_valid && m_valid && !m_ready |-> !s_ready);
endmodule

// File: tb/test_spx_readout.sv
`timescale 1ns/1ps
module test_spx_readout;
  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  typedef struct {
    int     row;
    int     col;
    int     diff;
    bit     eof;
    longint due;
    bit     lat;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_ready, trig = 0, m_valid, m_ready = 1, m_eof;
  logic [RW-1:0] s_row = '0, m_row;
  logic [CW-1:0] s_col = '0, m_col;
  logic [11:0] s_pixel = '0, thresh = 12'd50, m_diff;

  int checks = 0, errors = 0;
  longint cyc = 0;
  bit bp_en = 0, done = 0;
  logic [7:0] lfsr = 8'hA5;
  int refm [ROWS][COLS];
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spx_readout #(.ROWS(ROWS), .COLS(COLS)) i_spx_readout (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_row(s_row), .s_col(s_col), .s_pixel(s_pixel), .trig(trig),
    .thresh(thresh), .m_valid(m_valid), .m_ready(m_ready),
    .m_row(m_row), .m_col(m_col), .m_diff(m_diff), .m_eof(m_eof)
  );

  function automatic int pix_val(input int mode, input int r, input int c);
    int dl;
    case (mode)
      0: return 100 + 7 * r + 3 * c;
      1: begin
        if (r == 2) dl = (c % 2 != 0) ? -30 : 49;
        else case (c)
          0: dl = 50; 1: dl = 49; 2: dl = -5; 3: dl = 200; 4: dl = 0;
          default: dl = 3000;
        endcase
        return refm[r][c] + dl;
      end
      2: return refm[r][c] + ((c % 3 == 0) ? -20 : c * 5);
      3: return 400 + 11 * r + 2 * c;
      4: return 900 + 5 * r + c;
      5: return refm[r][c] + ((r == 1) ? 10 : (((r + c) % 2 == 0) ? 60 + r : 10));
      default: return refm[r][c] + ((c % 2 != 0) ? 5 : -5);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
  endtask

  // Driver: sends a full frame and files expected words with their due cycle
  task automatic send_frame(input int mode, input bit sig, input int trig_at, input bit lat);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int v, d, idx;
        longint at;
        idx = r * COLS + c;
        v = pix_val(mode, r, c);
        @(negedge clk);
        s_valid = 1; s_row = RW'(r); s_col = CW'(c); s_pixel = 12'(v);
        trig = (idx == trig_at);
        #2;
        while (!s_ready) begin @(negedge clk); #2; end
        at = cyc;
        if (sig) begin
          d = v - refm[r][c];
          if (d < 0) d = 0;
          if (d >= int'(thresh)) q.push_back('{r, c, d, 1'b0, at + 2, lat});
          if (idx == ROWS * COLS - 1) q.push_back('{0, 0, 0, 1'b1, at + 3, lat});
        end else begin
          refm[r][c] = v;
        end
      end
    end
    @(negedge clk); s_valid = 0; trig = 0;
  endtask

  task automatic drain(input string req);
    repeat (4) @(negedge clk);
    while (q.size() != 0 || m_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q.size() == 0 && !m_valid, req,
          $sformatf("pending=%0d m_valid=%0b expected 0/0", q.size(), m_valid));
  endtask

  // Monitor: pops expected words and compares content, order and timing
  initial begin
    bit prev_stall;
    logic [38:0] prev_word;
    prev_stall = 0;
    prev_word = '0;
    forever begin
      @(negedge clk);
      if (bp_en) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        m_ready = lfsr[0] | lfsr[2];
      end else m_ready = 1;
      if (rst_n && prev_stall)
        // R11
        check(m_valid && (39'({m_eof, m_row, m_col, m_diff}) == prev_word), "R11",
              $sformatf("stalled word changed to %h, expected %h",
                        39'({m_eof, m_row, m_col, m_diff}), prev_word));
      if (rst_n && m_valid && m_ready) begin
        if (q.size() == 0) begin
          // R2 R8 R9: no word may appear outside a signal frame
          check(0, "R2", $sformatf("unexpected word eof=%0b row=%0d col=%0d diff=%0d, expected none",
                                  m_eof, m_row, m_col, m_diff));
        end else begin
          exp_t e;
          e = q.pop_front();
          // R3 R4 R5 R6 R7 R10: content and order
          check(m_eof == e.eof && int'(m_row) == e.row && int'(m_col) == e.col &&
                int'(m_diff) == e.diff, e.eof ? "R7" : "R6",
                $sformatf("got eof=%0b r=%0d c=%0d d=%0d, expected eof=%0b r=%0d c=%0d d=%0d",
                          m_eof, m_row, m_col, m_diff, e.eof, e.row, e.col, e.diff));
          // R12
          if (e.lat)
            check(cyc == e.due, "R12", $sformatf("word at cycle %0d, expected %0d", cyc, e.due));
        end
      end
      prev_stall = m_valid && !m_ready;
      prev_word = 39'({m_eof, m_row, m_col, m_diff});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(!m_valid && s_ready, "R1",
          $sformatf("m_valid=%0b s_ready=%0b expected 0/1", m_valid, s_ready));
    send_frame(0, 0, -1, 1);
    drain("R2");
    pulse_trig();
    send_frame(1, 1, -1, 1);            // R3 R5 R6 empty row 2
    drain("R6");
    thresh = 12'd0;
    pulse_trig();
    send_frame(2, 1, 7, 1);             // R4 R10, trigger inside ignored (R9)
    drain("R10");
    send_frame(3, 0, -1, 1);            // R9: must be a refresh frame
    drain("R9");
    send_frame(4, 0, 10, 1);            // R8: trigger mid refresh frame
    drain("R8");
    thresh = 12'd50;
    bp_en = 1;
    send_frame(5, 1, -1, 0);            // R8 takes effect, R11 under stalls
    drain("R11");
    bp_en = 0;
    thresh = 12'd4095;
    pulse_trig();
    send_frame(6, 1, -1, 1);            // R7: only the end-of-frame word
    drain("R7");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule